// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small two-register processor. A micro-program counter addresses a control store, and each control word drives the strobes of the datapath: data memory read and write, the loads of the X and Y registers and of the flag, the source select in front of X, the ALU operation code, the program-memory read, the instruction-register load, and the program-counter source select and load. Each control word also carries a two-bit sequencing action. The action either restarts the fetch routine at micro-address zero, steps to the next micro-address, or jumps to the routine that an opcode map picks for the current instruction.

The block runs on one clock. Each micro-step takes one cycle. Every instruction takes three cycles: two fetch steps and one execute step. The instruction register contents and the ALU flag are inputs. The control outputs are combinational functions of the micro-program counter, and the conditional program-counter load also depends on the flag in the same cycle.

Top module: `ucode_ctrl`

## Requirements
- R1: While `rst_n` is low, the micro-program counter is held at zero, so the outputs show the first fetch step.
- R2: The first fetch step drives only `prog_rd` and `ir_load`. It always comes right after an execute step or after reset is released, and it is always followed by the second fetch step.
- R3: The second fetch step drives only `pc_load` with `pc_sel_ads` = 0 (select PC+1). The next cycle is the execute step chosen by `ir_word[15:12]`.
- R4: Opcode 0 (load X) drives `mem_rd` and `x_load` with `x_sel_alu` = 0 (memory source). The next step is a fetch.
- R5: Opcode 1 (load Y) drives `mem_rd` and `y_load` only.
- R6: Opcode 2 (store X) drives `mem_wr` only. `mem_rd` and `mem_wr` are never high together.
- R7: Opcode 3 (jump) drives `pc_sel_ads` = 1 and `pc_load` = 1.
- R8: Opcode 4 (jump if set) drives `pc_sel_ads` = 1 and sets `pc_load` equal to `alu_flag`. Opcode 5 (jump if clear) drives `pc_sel_ads` = 1 and sets `pc_load` equal to the inverse of `alu_flag`.
- R9: Opcode 6 (extended ALU) with `ir_word[11:3]` = 0 drives `alu_op` = `ir_word[2:0]` (0 add, 1 sub, 2 inc, 3 dec, 4 and, 5 or, 6 eq, 7 eqz). For codes 0 to 5 it also drives `x_sel_alu` = 1 and `x_load` = 1. For codes 6 and 7 it drives `flag_load` = 1 and leaves `x_load` low.
- R10: Opcodes 7 to 15, and opcode 6 with any bit of `ir_word[11:3]` set, give an execute step with every output low, followed by a fetch.
- R11: `alu_op` is 0 in every step that is not an extended ALU step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one micro-step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ir_word | input | 16 | Instruction register contents: opcode [15:12], address field [11:0] |
| alu_flag | input | 1 | ALU flag, used by the conditional jumps |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| x_load | output | 1 | Load enable for register X |
| y_load | output | 1 | Load enable for register Y |
| x_sel_alu | output | 1 | X input mux: 1 selects the ALU result, 0 selects memory |
| alu_op | output | 3 | ALU operation code |
| flag_load | output | 1 | Flag update enable |
| prog_rd | output | 1 | Program memory read strobe |
| ir_load | output | 1 | Instruction register load enable |
| pc_sel_ads | output | 1 | PC mux: 1 selects the address field, 0 selects PC+1 |
| pc_load | output | 1 | Program counter load enable |

## Verification
All outputs are combinational from the micro-program counter. Each output therefore belongs to the cycle whose step the counter holds. The first fetch step shows one cycle after reset release or after an execute step. The execute step for an instruction shows in the second cycle after its `ir_load`, and it reads `ir_word` as it stands during the second fetch step. The conditional `pc_load` of a jump follows `alu_flag` in the same cycle. The bench changes `ir_word` and `alu_flag` on the falling edge, compares the outputs 1 ns later against its phase model, and advances that model on each rising edge, so every comparison lands inside the cycle the step belongs to.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  // ALU operation code width (extended-op selector width)
  localparam int ALU_W = 3;

  // opcode values
  localparam int OPC_LDX = 0;
  localparam int OPC_LDY = 1;
  localparam int OPC_STX = 2;
  localparam int OPC_JMP = 3;
  localparam int OPC_JT  = 4;
  localparam int OPC_JF  = 5;
  localparam int OPC_XOP = 6;

  // micro-addresses of the routines
  localparam int UA_FETCH0 = 0;
  localparam int UA_FETCH1 = 1;
  localparam int UA_LDX    = 2;
  localparam int UA_LDY    = 3;
  localparam int UA_STX    = 4;
  localparam int UA_JMP    = 5;
  localparam int UA_JT     = 6;
  localparam int UA_JF     = 7;
  localparam int UA_NOP    = 8;
  localparam int UA_ALU    = 9;   // first of 2**ALU_W ALU steps
  localparam int UA_LAST   = UA_ALU + (1 << ALU_W) - 1;

  typedef enum logic [1:0] {
    SEQ_FETCH  = 2'd0,
    SEQ_NEXT   = 2'd1,
    SEQ_DECODE = 2'd2
  } seq_e;

  typedef enum logic [1:0] {
    PCL_NONE   = 2'd0,
    PCL_ALWAYS = 2'd1,
    PCL_IF_SET = 2'd2,
    PCL_IF_CLR = 2'd3
  } pcl_e;

  typedef struct packed {
    logic             mem_rd;
    logic             mem_wr;
    logic             x_ld;
    logic             y_ld;
    logic             x_sel_alu;
    logic [ALU_W-1:0] alu_op;
    logic             flag_ld;
    logic             prog_rd;
    logic             ir_ld;
    logic             pc_sel_ads;
    pcl_e             pc_kind;
    seq_e             seq;
  } ctrl_word_t;

endpackage

// File: rtl/ucode_map.sv
module ucode_map
  import ucode_pkg::*;
#(
  parameter int OP_W  = 4,
  parameter int ADS_W = 12,
  parameter int UPC_W = 5
) (
  input  logic [OP_W-1:0]  op,
  input  logic [ADS_W-1:0] ads,
  output logic [UPC_W-1:0] target
);

  localparam int HI_W = ADS_W - ALU_W;

  logic [ALU_W-1:0] sub_sel;
  logic [HI_W-1:0]  sub_hi;

  assign sub_sel = ads[ALU_W-1:0];
  assign sub_hi  = ads[ADS_W-1:ALU_W];

  always_comb begin
    target = UPC_W'(UA_NOP);
    if (op == OP_W'(OPC_LDX))      target = UPC_W'(UA_LDX);
    else if (op == OP_W'(OPC_LDY)) target = UPC_W'(UA_LDY);
    else if (op == OP_W'(OPC_STX)) target = UPC_W'(UA_STX);
    else if (op == OP_W'(OPC_JMP)) target = UPC_W'(UA_JMP);
    else if (op == OP_W'(OPC_JT))  target = UPC_W'(UA_JT);
    else if (op == OP_W'(OPC_JF))  target = UPC_W'(UA_JF);
    else if (op == OP_W'(OPC_XOP)) begin
      // reserved extended encodings fall to the no-op routine
      if (sub_hi == '0) target = UPC_W'(UA_ALU) + UPC_W'(sub_sel);
    end
  end

endmodule

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_pkg::*;
#(
  parameter int UPC_W = 5
) (
  input  logic [UPC_W-1:0] upc,
  output ctrl_word_t       cw
);

  localparam int ALU_N = 1 << ALU_W;

  always_comb begin
    cw         = '0;
    cw.pc_kind = PCL_NONE;
    cw.seq     = SEQ_FETCH;
    case (upc)
      UPC_W'(UA_FETCH0): begin
        cw.prog_rd = 1'b1;
        cw.ir_ld   = 1'b1;
        cw.seq     = SEQ_NEXT;
      end
      UPC_W'(UA_FETCH1): begin
        cw.pc_sel_ads = 1'b0;
        cw.pc_kind    = PCL_ALWAYS;
        cw.seq        = SEQ_DECODE;
      end
      UPC_W'(UA_LDX): begin
        cw.mem_rd    = 1'b1;
        cw.x_sel_alu = 1'b0;
        cw.x_ld      = 1'b1;
      end
      UPC_W'(UA_LDY): begin
        cw.mem_rd = 1'b1;
        cw.y_ld   = 1'b1;
      end
      UPC_W'(UA_STX): cw.mem_wr = 1'b1;
      UPC_W'(UA_JMP): begin
        cw.pc_sel_ads = 1'b1;
        cw.pc_kind    = PCL_ALWAYS;
      end
      UPC_W'(UA_JT): begin
        cw.pc_sel_ads = 1'b1;
        cw.pc_kind    = PCL_IF_SET;
      end
      UPC_W'(UA_JF): begin
        cw.pc_sel_ads = 1'b1;
        cw.pc_kind    = PCL_IF_CLR;
      end
      default: begin
        if (upc >= UPC_W'(UA_ALU) && upc <= UPC_W'(UA_LAST)) begin
          cw.alu_op = ALU_W'(upc - UPC_W'(UA_ALU));
          if (int'(cw.alu_op) < ALU_N - 2) begin
            cw.x_sel_alu = 1'b1;
            cw.x_ld      = 1'b1;
          end else begin
            cw.flag_ld = 1'b1;
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
#(
  parameter int UPC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_e             seq,
  input  logic [UPC_W-1:0] target,
  output logic [UPC_W-1:0] upc
);

  logic [UPC_W-1:0] upc_nxt;
  logic             upc_en;

  assign upc_en = 1'b1;  // one micro-step per cycle

  always_comb begin
    case (seq)
      SEQ_NEXT:   upc_nxt = upc + UPC_W'(1);
      SEQ_DECODE: upc_nxt = target;
      default:    upc_nxt = UPC_W'(UA_FETCH0);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upc <= UPC_W'(UA_FETCH0);
    else if (upc_en) upc <= upc_nxt;
  end

endmodule

// File: rtl/ucode_pcgate.sv
module ucode_pcgate
  import ucode_pkg::*;
(
  input  pcl_e kind,
  input  logic flag,
  output logic pc_load
);

  always_comb begin
    case (kind)
      PCL_ALWAYS: pc_load = 1'b1;
      PCL_IF_SET: pc_load = flag;
      PCL_IF_CLR: pc_load = ~flag;
      default:    pc_load = 1'b0;
    endcase
  end

endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
  import ucode_pkg::*;
#(
  parameter int OP_W  = 4,
  parameter int ADS_W = 12,
  parameter int UPC_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OP_W+ADS_W-1:0] ir_word,
  input  logic                  alu_flag,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic                  x_load,
  output logic                  y_load,
  output logic                  x_sel_alu,
  output logic [ALU_W-1:0]      alu_op,
  output logic                  flag_load,
  output logic                  prog_rd,
  output logic                  ir_load,
  output logic                  pc_sel_ads,
  output logic                  pc_load
);

  localparam int IR_W = OP_W + ADS_W;

  logic [UPC_W-1:0] upc;
  logic [UPC_W-1:0] target;
  ctrl_word_t       cw;

  ucode_map #(.OP_W(OP_W), .ADS_W(ADS_W), .UPC_W(UPC_W)) map_i (
    .op     (ir_word[IR_W-1:ADS_W]),
    .ads    (ir_word[ADS_W-1:0]),
    .target (target)
  );

  ucode_rom #(.UPC_W(UPC_W)) rom_i (
    .upc (upc),
    .cw  (cw)
  );

  ucode_seq #(.UPC_W(UPC_W)) seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .seq    (cw.seq),
    .target (target),
    .upc    (upc)
  );

  ucode_pcgate gate_i (
    .kind    (cw.pc_kind),
    .flag    (alu_flag),
    .pc_load (pc_load)
  );

  assign mem_rd     = cw.mem_rd;
  assign mem_wr     = cw.mem_wr;
  assign x_load     = cw.x_ld;
  assign y_load     = cw.y_ld;
  assign x_sel_alu  = cw.x_sel_alu;
  assign alu_op     = cw.alu_op;
  assign flag_load  = cw.flag_ld;
  assign prog_rd    = cw.prog_rd;
  assign ir_load    = cw.ir_ld;
  assign pc_sel_ads = cw.pc_sel_ads;

endmodule

// File: rtl/ucode_ctrl_chk.sv
module ucode_ctrl_chk #(
  parameter int OP_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OP_W-1:0] op,
  input logic            alu_flag,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            x_load,
  input logic            y_load,
  input logic            x_sel_alu,
  input logic [2:0]      alu_op,
  input logic            flag_load,
  input logic            prog_rd,
  input logic            ir_load,
  input logic            pc_sel_ads,
  input logic            pc_load
);

  // R2: first fetch step is always followed by the PC+1 step
  p_fetch_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> (pc_load && !pc_sel_ads && !ir_load && !prog_rd));

  // R3: the step after the PC+1 step is an execute step, never a fetch
  p_exec_after_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !pc_sel_ads) |=> (!ir_load && !prog_rd));

  // R4: a memory-sourced X load never selects the ALU
  p_ldx_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && x_load) |-> !x_sel_alu);

  // R6: read and write strobes are exclusive
  p_mem_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R8: jump-if-set loads the PC only with the flag set
  p_jt_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && pc_sel_ads && op == OP_W'(4)) |-> alu_flag);

  // R8: jump-if-clear loads the PC only with the flag clear
  p_jf_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && pc_sel_ads && op == OP_W'(5)) |-> !alu_flag);

  // R9: at most one destination is written per step
  p_one_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({x_load, y_load, flag_load, mem_wr}));

  // R11: ALU code stays 0 outside ALU steps
  p_alu_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_sel_alu && !flag_load) |-> (alu_op == 3'd0));

  // R2: after any execute step the next step is the first fetch step
  p_back_to_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || pc_sel_ads || flag_load) |=> (ir_load && prog_rd));

endmodule

bind ucode_ctrl ucode_ctrl_chk #(.OP_W(OP_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .op         (ir_word[OP_W+ADS_W-1:ADS_W]),
  .alu_flag   (alu_flag),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .x_load     (x_load),
  .y_load     (y_load),
  .x_sel_alu  (x_sel_alu),
  .alu_op     (alu_op),
  .flag_load  (flag_load),
  .prog_rd    (prog_rd),
  .ir_load    (ir_load),
  .pc_sel_ads (pc_sel_ads),
  .pc_load    (pc_load)
);

// File: tb/ucode_ctrl_tb_top.sv
`timescale 1ns/1ps
module ucode_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ir_word;
  logic        alu_flag;
  logic        mem_rd, mem_wr, x_load, y_load, x_sel_alu;
  logic [2:0]  alu_op;
  logic        flag_load, prog_rd, ir_load, pc_sel_ads, pc_load;

  always #5 clk = ~clk;

  ucode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ir_word(ir_word), .alu_flag(alu_flag),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .x_load(x_load), .y_load(y_load),
    .x_sel_alu(x_sel_alu), .alu_op(alu_op), .flag_load(flag_load),
    .prog_rd(prog_rd), .ir_load(ir_load), .pc_sel_ads(pc_sel_ads),
    .pc_load(pc_load)
  );

  int          phase;       // 0 fetch1, 1 fetch2, 2 execute
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;
  logic [15:0] instr_q[$];

  always @(posedge clk) begin
    if (!rst_n) phase <= 0;
    else        phase <= (phase == 2) ? 0 : phase + 1;
  end

  // expected strobes {mem_rd,mem_wr,x_load,y_load,x_sel_alu,flag_load,
  //                   prog_rd,ir_load,pc_sel_ads,pc_load} and ALU code
  task automatic model(input int ph, input logic [15:0] ir, input logic f,
                       output logic [9:0] exp_s, output logic [2:0] exp_a,
                       output bit is_alu, output string tag);
    int op;
    int sub;
    exp_s  = '0;
    exp_a  = 3'd0;
    is_alu = 1'b0;
    op     = int'(ir[15:12]);
    sub    = int'(ir[2:0]);
    if (!rst_n) begin
      exp_s = 10'b0000001100; tag = "R1";
    end else if (ph == 0) begin
      exp_s = 10'b0000001100; tag = "R2";
    end else if (ph == 1) begin
      exp_s = 10'b0000000001; tag = "R3";
    end else begin
      case (op)
        0: begin exp_s = 10'b1010000000; tag = "R4"; end
        1: begin exp_s = 10'b1001000000; tag = "R5"; end
        2: begin exp_s = 10'b0100000000; tag = "R6"; end
        3: begin exp_s = 10'b0000000011; tag = "R7"; end
        4: begin exp_s = {9'b000000001, f};  tag = "R8"; end
        5: begin exp_s = {9'b000000001, ~f}; tag = "R8"; end
        6: begin
          if (ir[11:3] == 9'd0) begin
            is_alu = 1'b1;
            exp_a  = 3'(sub);
            exp_s  = (sub < 6) ? 10'b0010100000 : 10'b0000010000;
            tag    = "R9";
          end else begin
            tag = "R10";
          end
        end
        default: tag = "R10";
      endcase
    end
  endtask

  task automatic compare();
    logic [9:0] exp_s;
    logic [9:0] got_s;
    logic [2:0] exp_a;
    bit         is_alu;
    string      tag;
    model(phase, ir_word, alu_flag, exp_s, exp_a, is_alu, tag);
    got_s = {mem_rd, mem_wr, x_load, y_load, x_sel_alu, flag_load,
             prog_rd, ir_load, pc_sel_ads, pc_load};
    vectors++;
    if (got_s !== exp_s) begin
      miscompares++;
      $display("FAIL %s strobes phase=%0d ir=%h flag=%b got=%b exp=%b",
               tag, phase, ir_word, alu_flag, got_s, exp_s);
    end
    vectors++;
    if (alu_op !== exp_a) begin
      miscompares++;
      $display("FAIL %s alu_op phase=%0d ir=%h got=%0d exp=%0d",
               is_alu ? "R9" : "R11", phase, ir_word, alu_op, exp_a);
    end
  endtask

  task automatic step(input bit rst_val);
    @(negedge clk);
    rst_n = rst_val;
    if (!rst_val) phase = 0;
    if (rst_val && phase == 1) begin
      if (instr_q.size() > 0) ir_word = instr_q.pop_front();
      else                    ir_word = 16'hF000;
    end
    alu_flag = 1'($urandom_range(0, 1));
    #1;
    compare();
  endtask

  initial begin
    int cyc;
    rst_n    = 1'b0;
    ir_word  = 16'h0000;
    alu_flag = 1'b0;
    // every opcode with two address values
    for (int o = 0; o < 16; o++) begin
      instr_q.push_back({4'(o), 12'h000});
      instr_q.push_back({4'(o), 12'(o * 193 + 7)});
    end
    // extended ALU codes, valid and reserved (R9, R10)
    for (int s = 0; s < 8; s++) instr_q.push_back({4'd6, 9'd0, 3'(s)});
    instr_q.push_back({4'd6, 12'h008});
    instr_q.push_back({4'd6, 12'h805});
    instr_q.push_back({4'd6, 12'hFFF});
    // conditional jumps repeated so both flag values are seen (R8)
    for (int k = 0; k < 16; k++) instr_q.push_back({4'(4 + (k % 2)), 12'(k)});
    for (int k = 0; k < 300; k++) instr_q.push_back(16'($urandom));

    // R1: reset held for several cycles
    repeat (3) step(1'b0);
    cyc = 0;
    while (instr_q.size() > 0 || phase != 0) begin
      if (cyc == 400) begin
        // R1: mid-run reset returns to fetch
        step(1'b0);
        step(1'b0);
      end
      step(1'b1);
      cyc++;
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R2 watchdog expired after 200000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule